// File: doc/BRIEF.md
# Smart Card Serial Status Register

This block produces the host-visible status byte of a half-duplex smart card serial port. It takes single-cycle event pulses from the rest of the port. The receive side reports a completed character along with three tags: parity error, missing stop bit, and a line that stayed silent for a whole character time. The transmit side reports each transfer of a character from the holding stage into the shift register, and the end of each shift. The host side reports writes to the transmit holding register and reads of the data and status registers.

A 16-entry receive FIFO sits inside the block. Each entry holds a received byte together with its three error tags. A separate counter tracks how many stored entries carry an error, so the summary bit follows the FIFO contents and not the read history. Four event flags hold their value until a status read clears them. The transmit side counts the bytes that are queued and keeps a shift-busy state. A one-cycle interrupt pulse fires when the transmit buffer empties and the interrupt is enabled.

Top module: `sc_uart_status`

## Requirements
- R1: After reset the status byte is 0x60 and `tbe_irq` is 0. Bit 6 (shift register empty) and bit 5 (buffer empty) are 1, and every other bit is 0.
- R2: Bit 0 is 1 while the receive FIFO holds at least one byte. `rx_rdata` shows the oldest byte. `host_rx_rd` removes it, so bytes come out in arrival order. A read of an empty FIFO has no effect.
- R3: A character that arrives while 16 entries are stored, with no read in the same cycle, replaces the newest stored entry. It also sets bit 1. The entry count stays at 16.
- R4: Bit 2 sets when a character arrives with its parity tag (`rx_par_err`) high. A status read clears it.
- R5: Bit 3 sets when a character arrives with its missing-stop tag (`rx_stop_err`) high. A status read clears it.
- R6: Bit 4 sets when a character arrives with its silent-word tag (`rx_silent`) high. A status read clears it.
- R7: When a set event and a status read fall in the same cycle, the flag (bits 1 to 4) ends at 1.
- R8: Bit 7 is 1 exactly while at least one stored entry carries a tag. A status read does not change it. It drops when the last tagged entry is read out or overwritten.
- R9: Bit 5 sets on a transfer (`tx_load`) while at least one byte is queued. It clears on `host_tx_wr`. If both happen in the same cycle, it ends at 1. A `tx_load` with nothing queued is ignored.
- R10: Bit 6 is 1 only when no transmit byte is queued and the shift register is idle. A transfer makes the shift register busy, and `tx_shift_done` makes it idle again. A write while 16 bytes are queued is dropped.
- R11: `tbe_irq` is high for exactly the one cycle in which bit 5 is set by a transfer, and only if `tbe_irq_en` was high at that edge.
- R12: Every status change becomes visible in the cycle after the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Received character complete (pulse) |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity tag of the character |
| rx_stop_err | input | 1 | Missing stop bit tag |
| rx_silent | input | 1 | Silent-word tag |
| tx_load | input | 1 | Holding stage to shift register transfer (pulse) |
| tx_shift_done | input | 1 | Shift register finished its character (pulse) |
| host_tx_wr | input | 1 | Host write to transmit holding register (pulse) |
| host_rx_rd | input | 1 | Host read of receive data (pulse) |
| host_sts_rd | input | 1 | Host read of the status byte (pulse) |
| tbe_irq_en | input | 1 | Transmit buffer empty interrupt enable |
| status | output | 8 | Status byte |
| rx_rdata | output | 8 | Oldest byte in the receive FIFO |
| tbe_irq | output | 1 | Transmit buffer empty interrupt pulse |

## Verification
The assertions assume that `tx_shift_done` pulses only while a character is in the shift register. They also assume that every event input is a one-cycle pulse sampled at the rising edge. The stimulus follows these rules by generating `tx_shift_done` only when the reference model shows the shift register busy, and by driving all pulses for one cycle from the falling edge. Overflowing reads, loads with an empty queue, and writes to a full queue are all driven on purpose, because the block must handle those itself.

// File: rtl/sc_uart_status.sv
module sc_uart_status #(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_stop_err,
  input  logic              rx_silent,
  input  logic              tx_load,
  input  logic              tx_shift_done,
  input  logic              host_tx_wr,
  input  logic              host_rx_rd,
  input  logic              host_sts_rd,
  input  logic              tbe_irq_en,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              tbe_irq
);
  localparam int RAW = $clog2(RX_DEPTH);
  localparam int CW  = RAW + 1;
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int EW  = DATA_W + 3;

  logic [EW-1:0]  mem [RX_DEPTH];
  logic [RAW-1:0] wp, rp;
  logic [CW-1:0]  rcnt, ecnt;
  logic [TCW-1:0] tcnt;
  logic oer, pber, nser, sbd, tbre, shb;

  wire rx_full  = rcnt == CW'(RX_DEPTH);
  wire pop      = host_rx_rd && rcnt != '0;
  wire ovw      = rx_done && rx_full && !pop;
  wire push     = rx_done && !ovw;
  wire new_err  = rx_done && (rx_par_err || rx_stop_err || rx_silent);
  wire [RAW-1:0] last = wp - 1'b1;
  wire head_err = |mem[rp][EW-1:DATA_W];
  wire last_err = |mem[last][EW-1:DATA_W];
  wire [EW-1:0] entry = {rx_silent, rx_stop_err, rx_par_err, rx_data};

  wire tx_ldv = tx_load && tcnt != '0;
  wire tx_acc = host_tx_wr && (tcnt != TCW'(TX_DEPTH) || tx_ldv);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= entry;
    else if (ovw) mem[last] <= entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      rcnt <= '0;
      ecnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      rcnt <= rcnt + CW'(push) - CW'(pop);
      ecnt <= ecnt + CW'(new_err) - CW'(pop && head_err) - CW'(ovw && last_err);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oer  <= 1'b0;
      pber <= 1'b0;
      nser <= 1'b0;
      sbd  <= 1'b0;
    end else begin
      oer  <= (oer  && !host_sts_rd) || ovw;
      pber <= (pber && !host_sts_rd) || (rx_done && rx_par_err);
      nser <= (nser && !host_sts_rd) || (rx_done && rx_stop_err);
      sbd  <= (sbd  && !host_sts_rd) || (rx_done && rx_silent);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt    <= '0;
      shb     <= 1'b0;
      tbre    <= 1'b1;
      tbe_irq <= 1'b0;
    end else begin
      tcnt    <= tcnt + TCW'(tx_acc) - TCW'(tx_ldv);
      shb     <= tx_ldv || (shb && !tx_shift_done);
      tbre    <= tx_ldv || (tbre && !host_tx_wr);
      tbe_irq <= tx_ldv && tbe_irq_en;
    end
  end

  assign status   = {ecnt != '0, tcnt == '0 && !shb, tbre, sbd, nser, pber, oer, rcnt != '0};
  assign rx_rdata = mem[rp][DATA_W-1:0];

  // R8
  err_le_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n) ecnt <= rcnt);
  // R2
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) rcnt <= CW'(RX_DEPTH));
  // R2
  rdr_set_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> status[0]);
  // R3
  ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full && !host_rx_rd |=> status[1] && rcnt == CW'(RX_DEPTH));
  // R4 R5 R6
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sts_rd && !rx_done |=> status[4:1] == 4'b0);
  // R9
  tbre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_wr && !tx_load |=> !status[5]);
  // R10
  tsre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_wr && !tx_load |=> !status[6]);
  // R11
  irq_tbre_chk: assert property (@(posedge clk) disable iff (!rst_n) tbe_irq |-> status[5]);
endmodule

// File: tb/sim_sc_uart_status.sv
module sim_sc_uart_status;
  logic clk = 0, rst_n = 0;
  logic rx_done = 0, rx_par = 0, rx_stop = 0, rx_sil = 0;
  logic [7:0] rx_data = 0;
  logic tx_load = 0, tx_sd = 0, tx_wr = 0, rx_rd = 0, sts_rd = 0, irq_en = 0;
  logic [7:0] status, rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sc_uart_status u0 (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_data(rx_data),
    .rx_par_err(rx_par), .rx_stop_err(rx_stop), .rx_silent(rx_sil),
    .tx_load(tx_load), .tx_shift_done(tx_sd), .host_tx_wr(tx_wr),
    .host_rx_rd(rx_rd), .host_sts_rd(sts_rd), .tbe_irq_en(irq_en),
    .status(status), .rx_rdata(rdata), .tbe_irq(irq));

  logic [10:0] q[$];
  bit m_oer, m_pber, m_nser, m_sbd, m_tbre = 1, m_shb, m_irq, m_ld, m_ov;
  int m_txn;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      {m_oer, m_pber, m_nser, m_sbd, m_shb, m_irq} = '0;
      m_tbre = 1; m_txn = 0;
    end else begin
      m_ld = tx_load && m_txn > 0;
      m_ov = 0;
      if (rx_rd && q.size() > 0) void'(q.pop_front());
      if (rx_done) begin
        if (q.size() == 16) begin q[q.size()-1] = {rx_sil, rx_stop, rx_par, rx_data}; m_ov = 1; end
        else q.push_back({rx_sil, rx_stop, rx_par, rx_data});
      end
      m_oer  = (m_oer  && !sts_rd) || m_ov;
      m_pber = (m_pber && !sts_rd) || (rx_done && rx_par);
      m_nser = (m_nser && !sts_rd) || (rx_done && rx_stop);
      m_sbd  = (m_sbd  && !sts_rd) || (rx_done && rx_sil);
      if (m_ld) begin m_txn--; m_shb = 1; end
      else if (tx_sd) m_shb = 0;
      if (tx_wr && m_txn < 16) m_txn++;
      m_tbre = m_ld ? 1'b1 : (tx_wr ? 1'b0 : m_tbre);
      m_irq = m_ld && irq_en;
    end
  end

  function automatic logic [7:0] exp_status();
    int e = 0;
    foreach (q[i]) if (q[i][10:8] != 0) e++;
    return {e > 0, m_txn == 0 && !m_shb, m_tbre, m_sbd, m_nser, m_pber, m_oer, q.size() > 0};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference model (R12)
  task automatic compare();
    check("R12 status", status, exp_status());
    check("R11 irq", {7'b0, irq}, {7'b0, m_irq});
    if (q.size() > 0) check("R2 rdata", rdata, q[0][7:0]);
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    if (rst_n) compare();
    {rx_done, rx_par, rx_stop, rx_sil, tx_load, tx_sd, tx_wr, rx_rd, sts_rd} = '0;
  endtask

  task automatic rx(logic [7:0] d, logic [2:0] t);
    rx_done = 1; rx_data = d; {rx_sil, rx_stop, rx_par} = t; cyc();
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", status, 8'h60);
    check("R1 reset irq", {7'b0, irq}, 8'h00);

    rx(8'hA1, 0); rx(8'hB2, 0); rx(8'hC3, 0);
    check("R2 rdr", status, 8'h61);
    check("R2 order first", rdata, 8'hA1);
    rx_rd = 1; cyc(); check("R2 order second", rdata, 8'hB2);
    rx_rd = 1; cyc(); rx_rd = 1; cyc();
    check("R2 empty", status, 8'h60);
    rx_rd = 1; cyc(); check("R2 empty read ignored", status, 8'h60);

    rx(8'h11, 3'b001);
    check("R4 parity set", status & 8'h84, 8'h84);
    sts_rd = 1; cyc();
    check("R4 parity cleared", status[2], 0);
    check("R8 summary kept", status[7], 1);
    rx_rd = 1; cyc();
    check("R8 summary drops", status[7], 0);

    rx(8'h22, 3'b010); check("R5 stop set", status[3], 1);
    rx(8'h33, 3'b100); check("R6 silent set", status[4], 1);
    sts_rd = 1; cyc(); check("R5 R6 cleared", status & 8'h18, 8'h00);
    rx_rd = 1; cyc(); check("R8 one tagged left", status[7], 1);
    rx_rd = 1; cyc(); check("R8 none left", status[7], 0);

    sts_rd = 1; rx(8'h44, 3'b001);
    check("R7 set wins", status[2], 1);
    sts_rd = 1; cyc(); rx_rd = 1; cyc();

    for (int i = 0; i < 16; i++) rx(8'(i), 0);
    check("R3 no overrun at 16", status[1], 0);
    rx(8'hEE, 3'b010);
    check("R3 overrun flag", status[1], 1);
    check("R8 overwrite tagged", status[7], 1);
    rx(8'hEF, 0);
    check("R8 overwrite removes tag", status[7], 0);
    for (int i = 0; i < 15; i++) begin rx_rd = 1; cyc(); end
    check("R3 newest replaced", rdata, 8'hEF);
    rx_rd = 1; sts_rd = 1; cyc();

    irq_en = 1;
    tx_load = 1; cyc(); check("R9 empty load ignored", {7'b0, irq}, 0);
    tx_wr = 1; cyc(); check("R9 write clears", status & 8'h60, 8'h00);
    tx_wr = 1; cyc();
    tx_load = 1; cyc();
    check("R9 load sets", status[5], 1);
    check("R11 irq pulse", {7'b0, irq}, 1);
    cyc(); check("R11 single pulse", {7'b0, irq}, 0);
    tx_load = 1; tx_wr = 1; cyc(); check("R9 set wins", status[5], 1);
    tx_load = 1; cyc(); tx_sd = 1; cyc();
    check("R10 idle", status[6], 1);
    irq_en = 0;
    for (int i = 0; i < 17; i++) begin tx_wr = 1; cyc(); end
    for (int i = 0; i < 16; i++) begin tx_load = 1; cyc(); end
    check("R11 disabled", {7'b0, irq}, 0);
    check("R10 shifting", status[6], 0);
    tx_sd = 1; cyc(); check("R10 full write dropped", status[6], 1);

    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      irq_en  = $urandom_range(0, 1);
      rx_done = r < 30; rx_data = 8'($urandom);
      {rx_sil, rx_stop, rx_par} = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0;
      rx_rd   = $urandom_range(0, 99) < 28;
      sts_rd  = $urandom_range(0, 99) < 15;
      tx_wr   = $urandom_range(0, 99) < 25;
      tx_load = $urandom_range(0, 99) < 20;
      tx_sd   = m_shb && $urandom_range(0, 99) < 30;
      cyc();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule